// File: doc/BRIEF.md
# Indexed widening SIMD multiplier

This block multiplies a vector of narrow integers by a single scalar and returns the double-width products. The vector is treated as a row of independent 128-bit segments. Inside each segment, an index chooses one narrow element of the second source, and that element is used as the scalar for the whole segment. It is multiplied by either the even or the odd narrow elements of the first source in the same segment. Every product is kept at full double width.

Control comes from a 32-bit instruction word. A small decoder inside the block extracts the element size, the signedness, the top/bottom choice, the index and the number of the second source register. A `start` pulse captures the word and both source vectors together. One registered stage later the destination vector appears with a one-cycle `out_valid`. A word that matches none of the eight legal forms raises `illegal` instead of starting a multiply.

Top module: `widen_idx_mul`

## Requirements
- R1: After reset, `out_valid` and `illegal` are 0 and `dst` is all zeros.
- R2: When `start` is sampled high with a legal word, `out_valid` is high for exactly one cycle, after the second rising edge that follows. Counting the capture edge as edge 1, this is the cycle after edge 2.
- R3: Each 128-bit segment takes its scalar from the same segment of `src_b`. The scalar is narrow element number `index` of that segment, where element j occupies bits [j*N +: N] and N is the narrow width.
- R4: The bottom form (word bit 10 = 0) multiplies the even narrow elements 2k of `src_a`. The top form (bit 10 = 1) multiplies the odd narrow elements 2k+1.
- R5: The signed form (word bits [15:12] = 1100) sign-extends both operands and keeps the full double-width product.
- R6: The unsigned form (word bits [15:12] = 1101) zero-extends both operands and keeps the full double-width product.
- R7: Size field [23:22] = 10 selects 16-bit inputs and 32-bit products. In this form the index is {bits[20:19], bit 11} (0..7) and `b_reg` is bits [18:16].
- R8: Size field [23:22] = 11 selects 32-bit inputs and 64-bit products. In this form the index is {bit 20, bit 11} (0..3) and `b_reg` is bits [19:16].
- R9: A word is legal only when all of the following hold: bits [31:24] = 0x44, bit 21 = 1, bit 23 = 1, and bits [15:13] = 110. For any other word, `start` makes `illegal` high for one cycle after the capture edge, no `out_valid` follows, and `dst` keeps its value.
- R10: Within a segment, wide result k occupies bits [k*W +: W], where W is the product width. A segment holds 128/W results.
- R11: `dst` changes only on the edge at which `out_valid` rises, and it holds its value between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture the word and operands on this edge |
| insn | input | 32 | Instruction word |
| src_a | input | VLEN | First source vector (multiplied lanes) |
| src_b | input | VLEN | Second source vector (indexed scalar) |
| dst | output | VLEN | Destination vector of wide products |
| out_valid | output | 1 | One-cycle pulse when `dst` is new |
| illegal | output | 1 | One-cycle pulse for an undecodable word |
| b_reg | output | 4 | Decoded second-source register number |

## Verification
The bench builds the block with VLEN = 384, which gives three segments. Three segments are enough to expose a scalar taken from the wrong segment, or a segment boundary misplaced by one lane. Signed and unsigned products, both sizes and every index value are reached by random words mixed with directed extreme operands (all ones, sign bit alone). Malformed words from each class of illegal field check that nothing starts and that `dst` holds.

// File: rtl/wim_pkg.sv
package wim_pkg;
  localparam int SEG_W = 128;

  typedef struct packed {
    logic       legal;
    logic       prod64;
    logic       uns;
    logic       top;
    logic [2:0] idx;
    logic [3:0] breg;
  } wim_ctl_t;

  // 16x16 -> 32, sign or zero extension chosen by sgn
  function automatic logic [31:0] mul_h(input logic [15:0] a, input logic [15:0] b,
                                        input logic sgn);
    logic signed [33:0] p;
    p = $signed({sgn & a[15], a}) * $signed({sgn & b[15], b});
    return p[31:0];
  endfunction

  // 32x32 -> 64
  function automatic logic [63:0] mul_w(input logic [31:0] a, input logic [31:0] b,
                                        input logic sgn);
    logic signed [65:0] p;
    p = $signed({sgn & a[31], a}) * $signed({sgn & b[31], b});
    return p[63:0];
  endfunction
endpackage

// File: rtl/wim_decode.sv
module wim_decode
  import wim_pkg::*;
(
  input  logic [31:0] insn,
  output wim_ctl_t    ctl
);
  logic fixed_ok;
  logic op_ok;

  assign fixed_ok = (insn[31:24] == 8'h44) && insn[21] && insn[23];
  assign op_ok    = (insn[15:13] == 3'b110);

  always_comb begin
    ctl        = '0;
    ctl.legal  = fixed_ok && op_ok;
    ctl.prod64 = insn[22];
    ctl.uns    = insn[12];
    ctl.top    = insn[10];
    if (insn[22]) begin
      ctl.idx  = {1'b0, insn[20], insn[11]};
      ctl.breg = insn[19:16];
    end else begin
      ctl.idx  = {insn[20:19], insn[11]};
      ctl.breg = {1'b0, insn[18:16]};
    end
  end
endmodule

// File: rtl/wim_segment.sv
module wim_segment
  import wim_pkg::*;
(
  input  logic [SEG_W-1:0] a_seg,
  input  logic [SEG_W-1:0] b_seg,
  input  logic             prod64,
  input  logic             uns,
  input  logic             top,
  input  logic [2:0]       idx,
  output logic [SEG_W-1:0] res
);
  localparam int NH = SEG_W / 32;  // 32-bit products per segment
  localparam int NW = SEG_W / 64;  // 64-bit products per segment

  logic [15:0] scal_h;
  logic [31:0] scal_w;

  assign scal_h = b_seg[idx*16 +: 16];
  assign scal_w = b_seg[idx[1:0]*32 +: 32];

  always_comb begin
    res = '0;
    if (!prod64) begin
      for (int k = 0; k < NH; k++)
        res[k*32 +: 32] = mul_h(a_seg[(2*k + int'(top))*16 +: 16], scal_h, !uns);
    end else begin
      for (int k = 0; k < NW; k++)
        res[k*64 +: 64] = mul_w(a_seg[(2*k + int'(top))*32 +: 32], scal_w, !uns);
    end
  end
endmodule

// File: rtl/widen_idx_mul.sv
module widen_idx_mul
  import wim_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     insn,
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  output logic [VLEN-1:0] dst,
  output logic            out_valid,
  output logic            illegal,
  output logic [3:0]      b_reg
);
  localparam int NSEG = VLEN / SEG_W;

  wim_ctl_t        dec;
  wim_ctl_t        s_ctl;
  logic [VLEN-1:0] s_a, s_b, comb_res;
  logic            stg_vld;
  logic            cap_fire;
  logic            bad_fire;

  wim_decode u_dec (.insn(insn), .ctl(dec));

  assign cap_fire = start && dec.legal;
  assign bad_fire = start && !dec.legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_a     <= '0;
      s_b     <= '0;
      s_ctl   <= '0;
      stg_vld <= 1'b0;
      illegal <= 1'b0;
      b_reg   <= '0;
    end else begin
      stg_vld <= cap_fire;
      illegal <= bad_fire;
      if (cap_fire) begin
        s_a   <= src_a;
        s_b   <= src_b;
        s_ctl <= dec;
        b_reg <= dec.breg;
      end
    end
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    wim_segment u_seg (
      .a_seg (s_a[g*SEG_W +: SEG_W]),
      .b_seg (s_b[g*SEG_W +: SEG_W]),
      .prod64(s_ctl.prod64),
      .uns   (s_ctl.uns),
      .top   (s_ctl.top),
      .idx   (s_ctl.idx),
      .res   (comb_res[g*SEG_W +: SEG_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= stg_vld;
      if (stg_vld) dst <= comb_res;
    end
  end
endmodule

// File: rtl/wim_chk.sv
module wim_chk #(
  parameter int VLEN = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            cap_fire,
  input logic            stg_vld,
  input logic            illegal,
  input logic            out_valid,
  input logic [VLEN-1:0] dst
);
  // R2
  valid_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(cap_fire, 2));
  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal, stg_vld}));
  // R9
  illegal_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !out_valid);
  // R9
  illegal_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(start));
  // R11
  dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(dst));
endmodule

bind widen_idx_mul wim_chk #(.VLEN(VLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cap_fire(cap_fire),
  .stg_vld(stg_vld), .illegal(illegal), .out_valid(out_valid), .dst(dst)
);

// File: tb/tb_widen_idx_mul.sv
module tb_widen_idx_mul;
  localparam int VLEN = 384;
  localparam int NSEG = VLEN / 128;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [31:0]     insn = '0;
  logic [VLEN-1:0] src_a = '0, src_b = '0;
  logic [VLEN-1:0] dst;
  logic            out_valid, illegal;
  logic [3:0]      b_reg;

  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  widen_idx_mul #(.VLEN(VLEN)) dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit p64, input bit uns, input bit top,
                                     input logic [2:0] idx, input logic [3:0] br);
    logic [31:0] w;
    w = 32'h4420_0000 | ($urandom & 32'h0000_03FF);
    w[23:22] = p64 ? 2'b11 : 2'b10;
    w[15:12] = {3'b110, uns};
    w[11] = idx[0];
    w[10] = top;
    if (p64) begin w[20] = idx[1]; w[19:16] = br; end
    else begin w[20:19] = idx[2:1]; w[18:16] = br[2:0]; end
    return w;
  endfunction

  function automatic logic [VLEN-1:0] model(input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                                            input bit p64, input bit uns, input bit top,
                                            input int idx);
    logic [VLEN-1:0] r = '0;
    int nw = p64 ? 32 : 16;
    longint unsigned nmask = p64 ? 64'hFFFF_FFFF : 64'hFFFF;
    longint unsigned wmask = p64 ? '1 : 64'hFFFF_FFFF;
    for (int s = 0; s < NSEG; s++) begin
      longint unsigned bv = 64'(b >> (s*128 + idx*nw)) & nmask;
      if (!uns && bv[nw-1]) bv = bv | ~nmask;
      for (int k = 0; k < 128/(2*nw); k++) begin
        longint unsigned av = 64'(a >> (s*128 + (2*k + (top ? 1 : 0))*nw)) & nmask;
        longint unsigned p;
        if (!uns && av[nw-1]) av = av | ~nmask;
        p = (av * bv) & wmask;
        r = r | ({{(VLEN-64){1'b0}}, p} << (s*128 + k*2*nw));
      end
    end
    return r;
  endfunction

  // legal run: checks latency (R2), product (tag), decoded register
  task automatic run_ok(input string tag, input bit p64, input bit uns, input bit top,
                        input logic [2:0] idx, input logic [3:0] br,
                        input logic [VLEN-1:0] a, input logic [VLEN-1:0] b);
    logic [VLEN-1:0] exp;
    exp = model(a, b, p64, uns, top, int'(idx));
    @(negedge clk);
    insn = mk(p64, uns, top, idx, br); src_a = a; src_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; src_a = '0; src_b = '0;
    chk("R2 early", VLEN'(out_valid), '0);
    @(negedge clk);
    chk("R2 valid", VLEN'(out_valid), VLEN'(1));
    chk(tag, dst, exp);
    chk(p64 ? "R8 breg" : "R7 breg", VLEN'(b_reg), VLEN'(p64 ? br : {1'b0, br[2:0]}));
    @(negedge clk);
    chk("R2 pulse", VLEN'(out_valid), '0);
  endtask

  task automatic run_bad(input string tag, input logic [31:0] w);
    logic [VLEN-1:0] prev;
    prev = dst;
    @(negedge clk);
    insn = w; src_a = '1; src_b = '1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " flag"}, VLEN'(illegal), VLEN'(1));
    @(negedge clk);
    chk({tag, " no valid"}, VLEN'(out_valid), '0);
    chk("R11 hold", dst, prev);
  endtask

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    logic [VLEN-1:0] a, b;
    void'($urandom(32'd1234));
    #1;
    chk("R1 valid", VLEN'(out_valid), '0);
    chk("R1 illegal", VLEN'(illegal), '0);
    chk("R1 dst", dst, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // per-segment scalar, distinct per segment (R3, R10)
    for (int s = 0; s < NSEG; s++) b[s*128 +: 128] = {8{16'(s*16 + 3)}} ^ 128'h0007_0006_0005_0004_0003_0002_0001_0000;
    a = '0;
    for (int i = 0; i < VLEN/16; i++) a[i*16 +: 16] = 16'(i + 1);
    run_ok("R3 seg idx5", 1'b0, 1'b1, 1'b0, 3'd5, 4'd3, a, b);
    run_ok("R10 lanes top", 1'b0, 1'b1, 1'b1, 3'd7, 4'd7, a, b);
    run_ok("R4 bottom 64", 1'b1, 1'b1, 1'b0, 3'd2, 4'd15, a, b);
    run_ok("R4 top 64", 1'b1, 1'b1, 1'b1, 3'd3, 4'd9, a, b);
    // extremes (R5, R6)
    run_ok("R5 signed all ones h", 1'b0, 1'b0, 1'b0, 3'd0, 4'd1, '1, '1);
    run_ok("R6 unsigned all ones h", 1'b0, 1'b1, 1'b1, 3'd7, 4'd2, '1, '1);
    run_ok("R5 signed min w", 1'b1, 1'b0, 1'b1, 3'd1, 4'd12, {VLEN/32{32'h8000_0000}}, {VLEN/32{32'h8000_0000}});
    run_ok("R6 unsigned ones w", 1'b1, 1'b1, 1'b0, 3'd3, 4'd8, '1, '1);

    // illegal classes (R9)
    run_bad("R9 size00", mk(1'b0, 1'b0, 1'b0, 3'd1, 4'd1) & ~32'h00C0_0000);
    run_bad("R9 op1110", mk(1'b0, 1'b0, 1'b0, 3'd1, 4'd1) | 32'h0000_2000);
    run_bad("R9 bit21", mk(1'b1, 1'b1, 1'b0, 3'd1, 4'd1) & ~32'h0020_0000);
    run_bad("R9 topbyte", mk(1'b1, 1'b0, 1'b1, 3'd1, 4'd1) ^ 32'h8000_0000);
    run_bad("R9 size01", (mk(1'b0, 1'b0, 1'b0, 3'd1, 4'd1) & ~32'h00C0_0000) | 32'h0040_0000);

    // random mix (R3..R8)
    for (int n = 0; n < 60; n++) begin
      bit p64 = 1'($urandom);
      bit uns = 1'($urandom);
      bit top = 1'($urandom);
      logic [2:0] idx = 3'($urandom);
      if (p64) idx[2] = 1'b0;
      run_ok(p64 ? (uns ? "R6 R8 rand" : "R5 R8 rand") : (uns ? "R6 R7 rand" : "R5 R7 rand"),
             p64, uns, top, idx, 4'($urandom), rnd_vec(), rnd_vec());
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule